// File: doc/BRIEF.md
# Frequency Lock State Controller

This block decides whether a clock-recovery loop should follow the incoming serial data or stay on the local reference clock. It counts how many recovered-clock cycles fall within a fixed window of reference-clock cycles and turns that count into an absolute frequency offset. It then moves a two-state lock machine between unlocked and locked. The thresholds it applies depend on the present state, so the block has hysteresis in parts per million rather than one fixed compare.

The recovered-clock count crosses into the reference domain through a toggle request/acknowledge pair. The block re-evaluates its state once per window, when a fresh measurement arrives. An external run-length-good flag, synchronous to the reference clock, gates everything. While that flag is low, the block cannot be locked and the loop is told to follow the reference. The window length and the four ppm limits are parameters. Each ppm limit becomes a count threshold equal to ppm x 2^WIN_LOG2 / 10^6, rounded to the nearest integer. The defaults (65536-cycle window, 244/366/488/732 ppm) give the thresholds 16, 24, 32 and 48.

Top module: `freq_lock_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `freq_lock_o` and `track_data_o` are 0 (unlocked, reference selected).
- R2: The offset is |N - 2^WIN_LOG2|, where N is the number of recovered-clock cycles between consecutive snapshots taken one window apart. Each threshold is round(ppm x 2^WIN_LOG2 / 10^6). With the default ppm limits these are acquire 16, acquire-reject 24, keep 32 and drop 48.
- R3: When locked, an offset of at most the drop threshold (48) leaves the block locked. This covers both the region below the keep threshold (32) and the dead band from 32 to 48.
- R4: When locked, an offset above the drop threshold (48) moves the block to unlocked at the next evaluation.
- R5: When unlocked, an offset below the acquire threshold (16) with the run-length flag high moves the block to locked at the next evaluation.
- R6: When unlocked, an offset of 16 or more leaves the block unlocked. This covers the dead band from 16 to 24, offsets above 24, and offsets that would keep a locked block locked.
- R7: A recovered clock that is slower than nominal is judged by the magnitude of its offset, the same way as a faster one.
- R8: The state changes only at an evaluation, once per window, or on loss of the run-length flag. The first snapshot after reset or after a stall only sets a baseline and produces no evaluation.
- R9: When `runlen_ok_i` is low, the block is unlocked at the next reference edge and stays unlocked for as long as the flag is low.
- R10: `track_data_o` is 1 only when the block is locked and `runlen_ok_i` is 1. It falls in the same cycle that `runlen_ok_i` falls.
- R11: A window that ends while a transfer is still unanswered counts as zero recovered cycles, so a stopped recovered clock unlocks the block. After the clock restarts, the block can lock again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference clock; all decisions are made in this domain |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| rec_clk | input | 1 | Recovered clock from the loop |
| runlen_ok_i | input | 1 | Run-length criterion satisfied, synchronous to ref_clk |
| freq_lock_o | output | 1 | 1 while the lock state machine is locked |
| track_data_o | output | 1 | 1 = loop follows incoming data, 0 = loop follows reference |

## Verification
The embedded properties check on every cycle the things that can be judged from a single trace. A rise of the lock output always follows an offset below the acquire threshold. A fall while the run-length flag was high always follows an offset above the drop threshold. Loss of the flag unlocks on the next edge. Evaluations come only from measurements, and measurements come only from acknowledged transfers or ended windows. The bench scenarios cover what needs a whole history of stimulus: which band a given offset lands in, hysteresis across a sequence of offsets, both signs of offset, the missing first evaluation, and recovery after the recovered clock stops.

// File: rtl/flc_pkg.sv
`timescale 1ns/1ps
package flc_pkg;

  typedef enum logic {
    LS_UNLOCKED = 1'b0,
    LS_LOCKED   = 1'b1
  } lock_st_t;

  typedef enum logic [1:0] {
    BAND_INSIDE  = 2'd0,
    BAND_DEAD    = 2'd1,
    BAND_OUTSIDE = 2'd2
  } band_t;

  // ppm limit -> count difference over a 2^wlog window, rounded to nearest
  function automatic logic [31:0] ppm_to_count(input int unsigned ppm,
                                               input int unsigned wlog);
    logic [63:0] scaled;
    scaled = (64'(ppm) << wlog) + 64'd500000;
    scaled = scaled / 64'd1000000;
    return scaled[31:0];
  endfunction

  // |count - 2^wlog|
  function automatic logic [31:0] abs_offset(input logic [31:0] count,
                                             input int unsigned wlog);
    logic [31:0] nominal;
    nominal = 32'd1 << wlog;
    if (count >= nominal) return count - nominal;
    return nominal - count;
  endfunction

  // state-dependent band: inside the near limit, outside the far limit, or between
  function automatic band_t classify(input lock_st_t    st,
                                     input logic [31:0] off,
                                     input logic [31:0] acq_cnt,
                                     input logic [31:0] rej_cnt,
                                     input logic [31:0] keep_cnt,
                                     input logic [31:0] drop_cnt);
    logic [31:0] near_lim;
    logic [31:0] far_lim;
    near_lim = (st == LS_LOCKED) ? keep_cnt : acq_cnt;
    far_lim  = (st == LS_LOCKED) ? drop_cnt : rej_cnt;
    if (off < near_lim) return BAND_INSIDE;
    if (off > far_lim)  return BAND_OUTSIDE;
    return BAND_DEAD;
  endfunction

  // dead band and agreeing bands hold the current state
  function automatic lock_st_t step_state(input lock_st_t st, input band_t band);
    if (st == LS_LOCKED && band == BAND_OUTSIDE) return LS_UNLOCKED;
    if (st == LS_UNLOCKED && band == BAND_INSIDE) return LS_LOCKED;
    return st;
  endfunction

endpackage

// File: rtl/flc_window_timer.sv
`timescale 1ns/1ps
module flc_window_timer #(
  parameter int unsigned WIN_LOG2 = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end_o
);

  logic [WIN_LOG2-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign win_end_o = &cnt_q;

  // R8
  win_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_o |=> !win_end_o);

  // R8
  win_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_end_o |=> (cnt_q == '0));

endmodule

// File: rtl/flc_count_xfer.sv
`timescale 1ns/1ps
module flc_count_xfer #(
  parameter int unsigned CNT_W = 19
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             rec_clk,
  input  logic             win_end_i,
  output logic             meas_valid_o,
  output logic [CNT_W-1:0] meas_count_o
);

  // ---------------- recovered-clock domain ----------------
  logic [1:0]       rrst_q;
  logic             rec_rst_n;
  logic [2:0]       req_sync_q;
  logic             req_seen;
  logic [CNT_W-1:0] free_cnt_q;
  logic [CNT_W-1:0] hold_q;
  logic             ack_tgl_q;

  // ---------------- reference-clock domain ----------------
  logic             req_tgl_q;
  logic             busy_q;
  logic             stale_q;
  logic             have_prev_q;
  logic [2:0]       ack_sync_q;
  logic             ack_seen;
  logic [CNT_W-1:0] snap_prev_q;
  logic             meas_valid_q;
  logic [CNT_W-1:0] meas_count_q;

  // reset for the recovered domain: asynchronous assert, synchronous release
  always_ff @(posedge rec_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) rrst_q <= 2'b00;
    else            rrst_q <= {rrst_q[0], 1'b1};
  end
  assign rec_rst_n = rrst_q[1];

  assign req_seen = req_sync_q[2] ^ req_sync_q[1];

  always_ff @(posedge rec_clk or negedge rec_rst_n) begin
    if (!rec_rst_n) begin
      req_sync_q <= '0;
      free_cnt_q <= '0;
      hold_q     <= '0;
      ack_tgl_q  <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[1:0], req_tgl_q};
      free_cnt_q <= free_cnt_q + 1'b1;
      if (req_seen) begin
        hold_q    <= free_cnt_q;
        ack_tgl_q <= ~ack_tgl_q;
      end
    end
  end

  assign ack_seen = ack_sync_q[2] ^ ack_sync_q[1];

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      req_tgl_q    <= 1'b0;
      busy_q       <= 1'b0;
      stale_q      <= 1'b0;
      have_prev_q  <= 1'b0;
      ack_sync_q   <= '0;
      snap_prev_q  <= '0;
      meas_valid_q <= 1'b0;
      meas_count_q <= '0;
    end else begin
      meas_valid_q <= 1'b0;
      ack_sync_q   <= {ack_sync_q[1:0], ack_tgl_q};
      if (ack_seen) begin
        busy_q      <= 1'b0;
        stale_q     <= 1'b0;
        snap_prev_q <= hold_q;
        have_prev_q <= ~stale_q;
        if (have_prev_q && !stale_q) begin
          meas_valid_q <= 1'b1;
          meas_count_q <= hold_q - snap_prev_q;
        end
      end
      if (win_end_i) begin
        if (busy_q && !ack_seen) begin
          // transfer still unanswered: recovered clock presumed stopped
          meas_valid_q <= 1'b1;
          meas_count_q <= '0;
          have_prev_q  <= 1'b0;
          stale_q      <= 1'b1;
        end else begin
          req_tgl_q <= ~req_tgl_q;
          busy_q    <= 1'b1;
        end
      end
    end
  end

  assign meas_valid_o = meas_valid_q;
  assign meas_count_o = meas_count_q;

  // R8
  ack_when_busy_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    ack_seen |-> busy_q);

  // R8
  meas_source_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    meas_valid_o |-> ($past(ack_seen) || $past(win_end_i)));

  // R8
  meas_spaced_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    meas_valid_o |=> !meas_valid_o);

  // R11
  stall_marks_stale_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (win_end_i && busy_q && !ack_seen) |=> (stale_q && !have_prev_q));

endmodule

// File: rtl/flc_offset_judge.sv
`timescale 1ns/1ps
module flc_offset_judge
  import flc_pkg::*;
#(
  parameter int unsigned WIN_LOG2       = 16,
  parameter int unsigned CNT_W          = 19,
  parameter int unsigned ACQ_PPM        = 244,
  parameter int unsigned ACQ_REJECT_PPM = 366,
  parameter int unsigned KEEP_PPM       = 488,
  parameter int unsigned DROP_PPM       = 732
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             meas_valid_i,
  input  logic [CNT_W-1:0] meas_count_i,
  input  lock_st_t         state_i,
  output logic             judge_valid_o,
  output logic [31:0]      offset_o,
  output band_t            band_o
);

  localparam int unsigned PADW     = 32 - CNT_W;
  localparam logic [31:0] ACQ_CNT  = ppm_to_count(ACQ_PPM, WIN_LOG2);
  localparam logic [31:0] REJ_CNT  = ppm_to_count(ACQ_REJECT_PPM, WIN_LOG2);
  localparam logic [31:0] KEEP_CNT = ppm_to_count(KEEP_PPM, WIN_LOG2);
  localparam logic [31:0] DROP_CNT = ppm_to_count(DROP_PPM, WIN_LOG2);

  logic [31:0] count32;
  logic [31:0] offset_q;
  logic        judge_valid_q;

  assign count32 = {{PADW{1'b0}}, meas_count_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      judge_valid_q <= 1'b0;
      offset_q      <= '0;
    end else begin
      judge_valid_q <= meas_valid_i;
      if (meas_valid_i) offset_q <= abs_offset(count32, WIN_LOG2);
    end
  end

  // band uses the state as it is now, so a state change between
  // measurement and decision never applies the wrong pair of limits
  assign band_o        = classify(state_i, offset_q, ACQ_CNT, REJ_CNT, KEEP_CNT, DROP_CNT);
  assign judge_valid_o = judge_valid_q;
  assign offset_o      = offset_q;

  // R8
  judge_follows_meas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    judge_valid_o |-> $past(meas_valid_i));

  // R2
  offset_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(meas_valid_i) |-> $stable(offset_o));

  // R11
  zero_count_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid_i && meas_count_i == '0) |=> (band_o == BAND_OUTSIDE));

endmodule

// File: rtl/flc_lock_fsm.sv
`timescale 1ns/1ps
module flc_lock_fsm
  import flc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     run_ok_i,
  input  logic     judge_valid_i,
  input  band_t    band_i,
  output lock_st_t state_o
);

  lock_st_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             state_q <= LS_UNLOCKED;
    else if (!run_ok_i)     state_q <= LS_UNLOCKED;
    else if (judge_valid_i) state_q <= step_state(state_q, band_i);
  end

  assign state_o = state_q;

  // R9
  run_loss_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok_i |=> (state_o == LS_UNLOCKED));

  // R8
  change_needs_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o != $past(state_o)) && $past(run_ok_i)) |-> $past(judge_valid_i));

endmodule

// File: rtl/freq_lock_ctrl.sv
`timescale 1ns/1ps
module freq_lock_ctrl
  import flc_pkg::*;
#(
  parameter int unsigned WIN_LOG2       = 16,
  parameter int unsigned CNT_HEADROOM   = 3,
  parameter int unsigned ACQ_PPM        = 244,
  parameter int unsigned ACQ_REJECT_PPM = 366,
  parameter int unsigned KEEP_PPM       = 488,
  parameter int unsigned DROP_PPM       = 732
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic rec_clk,
  input  logic runlen_ok_i,
  output logic freq_lock_o,
  output logic track_data_o
);

  localparam int unsigned CNT_W    = WIN_LOG2 + CNT_HEADROOM;
  localparam logic [31:0] ACQ_CNT  = ppm_to_count(ACQ_PPM, WIN_LOG2);
  localparam logic [31:0] DROP_CNT = ppm_to_count(DROP_PPM, WIN_LOG2);

  logic             win_end_w;
  logic             meas_valid_w;
  logic [CNT_W-1:0] meas_count_w;
  logic             judge_valid_w;
  logic [31:0]      offset_w;
  band_t            band_w;
  lock_st_t         state_w;

  flc_window_timer #(.WIN_LOG2(WIN_LOG2)) u_timer (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .win_end_o (win_end_w)
  );

  flc_count_xfer #(.CNT_W(CNT_W)) u_xfer (
    .ref_clk      (ref_clk),
    .ref_rst_n    (rst_n),
    .rec_clk      (rec_clk),
    .win_end_i    (win_end_w),
    .meas_valid_o (meas_valid_w),
    .meas_count_o (meas_count_w)
  );

  flc_offset_judge #(
    .WIN_LOG2       (WIN_LOG2),
    .CNT_W          (CNT_W),
    .ACQ_PPM        (ACQ_PPM),
    .ACQ_REJECT_PPM (ACQ_REJECT_PPM),
    .KEEP_PPM       (KEEP_PPM),
    .DROP_PPM       (DROP_PPM)
  ) u_judge (
    .clk           (ref_clk),
    .rst_n         (rst_n),
    .meas_valid_i  (meas_valid_w),
    .meas_count_i  (meas_count_w),
    .state_i       (state_w),
    .judge_valid_o (judge_valid_w),
    .offset_o      (offset_w),
    .band_o        (band_w)
  );

  flc_lock_fsm u_fsm (
    .clk           (ref_clk),
    .rst_n         (rst_n),
    .run_ok_i      (runlen_ok_i),
    .judge_valid_i (judge_valid_w),
    .band_i        (band_w),
    .state_o       (state_w)
  );

  assign freq_lock_o  = (state_w == LS_LOCKED);
  assign track_data_o = freq_lock_o & runlen_ok_i;

  // R5
  grant_needs_near_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(freq_lock_o) |-> (($past(offset_w) < ACQ_CNT) && $past(runlen_ok_i)));

  // R4
  revoke_needs_far_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
    ($fell(freq_lock_o) && $past(runlen_ok_i)) |-> ($past(offset_w) > DROP_CNT));

endmodule

// File: tb/freq_lock_ctrl_bench.sv
`timescale 1ns/1ps
module freq_lock_ctrl_bench;

  localparam int WLOG = 10;
  localparam int WIN  = 1 << WLOG;
  // count thresholds the bench expects from the requirements
  localparam int T_ACQ  = 16;
  localparam int T_DROP = 48;

  logic ref_clk = 1'b0;
  logic rec_clk = 1'b0;
  logic rst_n   = 1'b0;
  logic runlen_ok = 1'b0;
  logic freq_lock;
  logic track_data;

  real rec_half = 4.0;
  bit  rec_run  = 1'b1;
  int  cur_delta = 0;
  bit  m_lock = 1'b0;
  int  n_tests = 0;
  int  n_fail  = 0;
  bit  finished = 1'b0;

  // ppm limits scaled so that a 1024-cycle window yields 16/24/32/48
  freq_lock_ctrl #(
    .WIN_LOG2       (WLOG),
    .ACQ_PPM        (15625),
    .ACQ_REJECT_PPM (23438),
    .KEEP_PPM       (31250),
    .DROP_PPM       (46875)
  ) u_freq_lock_ctrl (
    .ref_clk      (ref_clk),
    .rst_n        (rst_n),
    .rec_clk      (rec_clk),
    .runlen_ok_i  (runlen_ok),
    .freq_lock_o  (freq_lock),
    .track_data_o (track_data)
  );

  always #4 ref_clk = ~ref_clk;

  initial begin
    forever begin
      if (rec_run) #(rec_half) rec_clk = ~rec_clk;
      else         #(1.0);
    end
  end

  function automatic bit model_step(bit st, int off);
    if (st) return !(off > T_DROP);
    return (off < T_ACQ);
  endfunction

  task automatic check_bit(string req, string what, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic set_delta(int d);
    cur_delta = d;
    rec_half  = 4.0 * real'(WIN) / (real'(WIN) + real'(d));
  endtask

  task automatic wait_windows(int n);
    repeat (n * WIN + 40) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  // apply an offset, let it settle, compare with the bench model
  task automatic settle_and_check(string req, int d);
    int a;
    set_delta(d);
    wait_windows(3);
    a = (d < 0) ? -d : d;
    m_lock = model_step(model_step(m_lock, a), a);
    check_bit(req, $sformatf("lock after offset %0d", d), freq_lock, m_lock);
    check_bit("R10", $sformatf("select after offset %0d", d), track_data, m_lock);
  endtask

  task automatic sc_reset_first_lock();
    set_delta(0);
    rst_n = 1'b0;
    runlen_ok = 1'b1;
    repeat (5) @(posedge ref_clk);
    @(negedge ref_clk);
    check_bit("R1", "lock in reset", freq_lock, 1'b0);
    check_bit("R1", "select in reset", track_data, 1'b0);
    rst_n = 1'b1;
    @(negedge ref_clk);
    check_bit("R1", "lock after reset", freq_lock, 1'b0);
    // first window only seeds the baseline
    repeat (WIN + WIN / 2) @(posedge ref_clk);
    @(negedge ref_clk);
    check_bit("R8", "no lock from first snapshot", freq_lock, 1'b0);
    repeat (WIN / 2 + 60) @(posedge ref_clk);
    @(negedge ref_clk);
    m_lock = 1'b1;
    check_bit("R5", "lock after second window", freq_lock, 1'b1);
    check_bit("R10", "select when locked", track_data, 1'b1);
  endtask

  task automatic sc_locked_hold();
    settle_and_check("R3", 28);
    settle_and_check("R3", 40);
  endtask

  task automatic sc_drop();
    settle_and_check("R4", 70);
  endtask

  task automatic sc_unlocked_hysteresis();
    settle_and_check("R6", 40);
    settle_and_check("R6", 28);
    settle_and_check("R6", 20);
  endtask

  task automatic sc_reacquire();
    settle_and_check("R5", 4);
  endtask

  task automatic sc_negative();
    settle_and_check("R7", -40);
    settle_and_check("R7", -70);
    settle_and_check("R7", -4);
  endtask

  task automatic sc_runlen_loss();
    settle_and_check("R5", 0);
    @(negedge ref_clk);
    runlen_ok = 1'b0;
    #1;
    check_bit("R10", "select falls with flag", track_data, 1'b0);
    @(negedge ref_clk);
    check_bit("R9", "unlock one edge after flag loss", freq_lock, 1'b0);
    wait_windows(3);
    check_bit("R9", "no relock while flag low", freq_lock, 1'b0);
    check_bit("R10", "select low while flag low", track_data, 1'b0);
    runlen_ok = 1'b1;
    wait_windows(2);
    check_bit("R5", "relock after flag returns", freq_lock, 1'b1);
    m_lock = 1'b1;
  endtask

  task automatic sc_clock_stall();
    rec_run = 1'b0;
    wait_windows(3);
    check_bit("R11", "unlock with stopped recovered clock", freq_lock, 1'b0);
    check_bit("R11", "reference selected with stopped clock", track_data, 1'b0);
    rec_run = 1'b1;
    wait_windows(5);
    check_bit("R11", "relock after clock restarts", freq_lock, 1'b1);
    m_lock = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge ref_clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    sc_reset_first_lock();
    sc_locked_hold();
    sc_drop();
    sc_unlocked_hysteresis();
    sc_reacquire();
    sc_negative();
    sc_runlen_loss();
    sc_clock_stall();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule